// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width. It produces one quotient bit per clock cycle. A start pulse is accepted only while the block is idle. It loads three registers in the same cycle: the dividend register, the divisor register, and a partial-remainder register that is one bit wider than the operands and starts at zero.

Each step then does three things in one cycle:
- It shifts the partial-remainder/dividend pair left by one bit.
- It makes a trial subtraction of the divisor.
- If the trial result is negative, it adds the divisor back and shifts in a zero quotient bit. Otherwise it keeps the difference and shifts in a one.

After `WIDTH` steps the dividend register holds the quotient and the low bits of the partial remainder hold the remainder. A one-cycle completion pulse marks the moment the results become valid. The results then stay unchanged until the next accepted start.

A zero divisor is flagged. The result in that case is well defined: the quotient is all ones and the remainder equals the dividend. Such an operation takes the same number of cycles as any other.

Top module: `restoring_udiv`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `div_by_zero` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high at a rising edge while `busy` is low loads the operands, and `busy` is high in the following cycle.
- R3: `busy` stays high for exactly `WIDTH` cycles after an accepted start. `done` is high for exactly one cycle: the first cycle in which `busy` reads low again.
- R4: With a non-zero divisor, when `done` is high, `quotient` equals the integer part of dividend/divisor and `remainder` equals dividend modulo divisor. Both are for the operands captured at the accepted start.
- R5: With a non-zero divisor, the `remainder` presented with `done` is strictly less than the divisor.
- R6: A zero divisor sets `div_by_zero` to 1 from the cycle after the accepted start. It gives `quotient` all ones and `remainder` equal to the dividend, with the same latency as R3.
- R7: A `start` sampled while `busy` is high is ignored: the running operation finishes on time with the operands originally captured.
- R8: While `busy` is low, `quotient`, `remainder` and `div_by_zero` hold their values until a start is accepted, regardless of the operand inputs.
- R9: Dividing 14 by 3 at the default width gives quotient 4 and remainder 2.
- R10: An accepted start with a non-zero divisor clears `div_by_zero` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | WIDTH | Unsigned dividend, sampled with an accepted start |
| divisor | input | WIDTH | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | High while division steps are running |
| done | output | 1 | One-cycle pulse when results become valid |
| quotient | output | WIDTH | Quotient, valid while busy is low |
| remainder | output | WIDTH | Remainder, valid while busy is low |
| div_by_zero | output | 1 | Captured divisor was zero, valid while busy is low |

## Verification
A wrong quotient bit is decided in a single step, and every later step only shifts it. It therefore appears unchanged in `quotient` in the `done` cycle, no more than `WIDTH` cycles after the step that got it wrong.

A missing or spurious add-back behaves differently. It leaves a partial remainder that is too large, or one that has wrapped, and that error spreads into all the quotient bits that follow. It shows at `done` as a remainder that is not below the divisor, or as a broken quotient-times-divisor-plus-remainder identity.

Step-counter faults show in the cycle where `done` rises, earlier or later than `WIDTH` cycles after the start. Every divisor/dividend pair at the default width is run, which reaches every add-back pattern.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } udiv_phase_e;

    // Bits needed to hold the value n (at least one).
    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) begin
            w++;
        end
        return w;
    endfunction

endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = bits_for(WIDTH);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(WIDTH);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    udiv_phase_e      phase_q;
    logic [CNT_W-1:0] left_q;
    logic             done_q;

    assign load    = start && (phase_q == PH_IDLE);
    assign step_en = (phase_q == PH_RUN);
    assign busy    = (phase_q == PH_RUN);
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_RUN;
                        left_q  <= STEPS;
                    end
                end
                PH_RUN: begin
                    left_q <= left_q - ONE;
                    if (left_q == ONE) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/udiv_step.sv
module udiv_step #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH:0]   part_in,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] dsr,
    output logic [WIDTH:0]   part_out,
    output logic [WIDTH-1:0] acc_out,
    output logic             went_neg
);
    localparam int unsigned PAIR_W = 2 * WIDTH + 1;

    logic [PAIR_W-1:0] pair_shl;
    logic [WIDTH:0]    top_bits;
    logic [WIDTH:0]    trial;
    logic [WIDTH:0]    dsr_ext;

    always_comb begin
        pair_shl = {part_in, acc_in} << 1;
        top_bits = pair_shl[PAIR_W-1:WIDTH];
        dsr_ext  = {1'b0, dsr};
        trial    = top_bits - dsr_ext;
        went_neg = trial[WIDTH];
        if (went_neg) begin
            // restore by adding the divisor back
            part_out = trial + dsr_ext;
            acc_out  = {pair_shl[WIDTH-1:1], 1'b0};
        end else begin
            part_out = trial;
            acc_out  = {pair_shl[WIDTH-1:1], 1'b1};
        end
    end
endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step_en,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] acc,
    output logic [WIDTH:0]   part,
    output logic             zero_dsr
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH:0]   part_q;
    logic [WIDTH-1:0] dsr_q;
    logic             zero_q;
    logic [WIDTH-1:0] acc_nx;
    logic [WIDTH:0]   part_nx;
    logic             neg_unused;

    udiv_step #(.WIDTH(WIDTH)) i_step (
        .part_in  (part_q),
        .acc_in   (acc_q),
        .dsr      (dsr_q),
        .part_out (part_nx),
        .acc_out  (acc_nx),
        .went_neg (neg_unused)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            part_q <= '0;
            dsr_q  <= '0;
            zero_q <= 1'b0;
        end else if (load) begin
            acc_q  <= dividend;
            part_q <= '0;
            dsr_q  <= divisor;
            zero_q <= (divisor == '0);
        end else if (step_en) begin
            acc_q  <= acc_nx;
            part_q <= part_nx;
        end
    end

    assign acc      = acc_q;
    assign part     = part_q;
    assign zero_dsr = zero_q;
endmodule

// File: rtl/restoring_udiv.sv
module restoring_udiv #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_by_zero
);
    logic           load;
    logic           step_en;
    logic [WIDTH:0] part;
    logic           part_sign_unused;

    udiv_ctrl #(.WIDTH(WIDTH)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    udiv_datapath #(.WIDTH(WIDTH)) i_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step_en  (step_en),
        .dividend (dividend),
        .divisor  (divisor),
        .acc      (quotient),
        .part     (part),
        .zero_dsr (div_by_zero)
    );

    assign remainder        = part[WIDTH-1:0];
    assign part_sign_unused = part[WIDTH];
endmodule

// File: rtl/restoring_udiv_chk.sv
module restoring_udiv_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             div_by_zero
);
    localparam int unsigned CW = udiv_pkg::bits_for(WIDTH + 1);
    localparam int unsigned MW = 2 * WIDTH + 1;

    logic             rst_q;
    logic             warm_q;
    logic [WIDTH-1:0] cap_a;
    logic [WIDTH-1:0] cap_b;
    logic [CW-1:0]    run_cnt;
    logic [MW-1:0]    recon;

    assign recon = MW'(quotient) * MW'(cap_b) + MW'(remainder);

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        warm_q <= !rst;
        if (rst) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= '0;
        end else if (start && !busy) begin
            cap_a   <= dividend;
            cap_b   <= divisor;
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_idle: assert (!busy && !done && !div_by_zero &&
                                     quotient == '0 && remainder == '0);
        end
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        (done && warm_q) |-> (!busy && $past(busy)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CW'(WIDTH)));

    a_r4_identity: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (recon == MW'(cap_a)));

    a_r5_rem_below: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (remainder < cap_b));

    a_r6_zero_result: assert property (@(posedge clk) disable iff (rst)
        (done && div_by_zero) |-> (cap_b == '0 && quotient == '1 &&
                                   remainder == cap_a));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (warm_q && !busy && $past(!busy && !start)) |->
            ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

    a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor != '0) |=> !div_by_zero);
endmodule

bind restoring_udiv restoring_udiv_chk #(.WIDTH(WIDTH)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
);

// File: tb/test_restoring_udiv.sv
module test_restoring_udiv;
    localparam int unsigned W = 4;
    localparam int unsigned MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    restoring_udiv #(.WIDTH(W)) i_restoring_udiv (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    bit exp_busy = 0, exp_done = 0, exp_dz = 0;
    int exp_q = 0, exp_r = 0, pend_q = 0, pend_r = 0, left = 0;
    bit pend_dz = 0;

    always @(posedge clk) begin
        if (rst) begin
            exp_busy = 0; exp_done = 0; exp_dz = 0; exp_q = 0; exp_r = 0; left = 0;
        end else begin
            exp_done = 0;
            if (exp_busy) begin
                left--;
                if (left == 0) begin
                    exp_busy = 0; exp_done = 1; exp_q = pend_q; exp_r = pend_r; exp_dz = pend_dz;
                end
            end else if (start) begin
                exp_busy = 1; left = W;
                pend_dz = (divisor == 0);
                exp_dz = pend_dz;
                if (divisor == 0) begin
                    pend_q = MAXV; pend_r = dividend;
                end else begin
                    pend_q = dividend / divisor; pend_r = dividend % divisor;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == exp_busy, "R3 busy", busy, exp_busy);
            chk(done == exp_done, "R3 done", done, exp_done);
            if (!exp_busy) begin
                chk(div_by_zero == exp_dz, "R6 flag", div_by_zero, exp_dz);
                chk(quotient == exp_q, exp_dz ? "R6 quotient" : "R4 quotient", quotient, exp_q);
                chk(remainder == exp_r, exp_dz ? "R6 remainder" : "R4 remainder", remainder, exp_r);
            end
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk(0, "R3 done timeout", 0, 1);
    endtask

    task automatic run_op(input int a, input int b);
        @(negedge clk);
        dividend = W'(a); divisor = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_done();
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(!busy && !done && !div_by_zero, "R1 flags", {busy, done, div_by_zero}, 0);
        chk(quotient == 0 && remainder == 0, "R1 data", {quotient, remainder}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && quotient == 0, "R1 after release", {busy, quotient}, 0);

        // R9
        run_op(14, 3);
        chk(quotient == 4, "R9 quotient", quotient, 4);
        chk(remainder == 2, "R9 remainder", remainder, 2);

        // R8: inputs change, no start
        dividend = 4'd9; divisor = 4'd2;
        repeat (4) @(negedge clk);
        chk(quotient == 4 && remainder == 2, "R8 hold", {quotient, remainder}, {4'd4, 4'd2});

        // R6 then R10
        run_op(11, 0);
        chk(div_by_zero == 1, "R6 flag", div_by_zero, 1);
        chk(quotient == MAXV && remainder == 11, "R6 result", {quotient, remainder}, {4'hF, 4'd11});
        run_op(7, 7);
        chk(div_by_zero == 0, "R10 flag cleared", div_by_zero, 0);
        chk(quotient == 1 && remainder == 0, "R4 equal operands", {quotient, remainder}, {4'd1, 4'd0});

        // R7: start while busy
        @(negedge clk);
        dividend = 4'd15; divisor = 4'd4; start = 1'b1;
        @(negedge clk);
        dividend = 4'd3; divisor = 4'd1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(quotient == 3 && remainder == 3, "R7 ignored start", {quotient, remainder}, {4'd3, 4'd3});

        // R3/R2: start in the done cycle is accepted
        dividend = 4'd13; divisor = 4'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1, "R2 back-to-back", busy, 1);
        wait_done();
        chk(quotient == 2 && remainder == 3, "R4 back-to-back", {quotient, remainder}, {4'd2, 4'd3});

        // exhaustive R4/R5/R6
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                run_op(a, b);
                if (b != 0) chk(remainder < b, "R5 remainder below divisor", remainder, b);
            end
        end
        repeat (2) @(negedge clk);
        summary();
    end
endmodule